// File: doc/BRIEF.md
# Edge-Selectable External Interrupt Unit with Event Timestamp

The block takes three asynchronous external interrupt pins and turns each into a maskable interrupt request. Each pin is moved into the clock domain through a two-flop synchroniser. Edge detection then works on the synchronised level. For each input, software selects whether a rising or a falling transition counts, and whether the input is enabled at all. A qualifying transition produces a request pulse that lasts one clock.

Each maskable input has its own 16-bit counter. The counter advances on every clock and returns to zero on the clock that raises that input's request. Reading the counter therefore tells software how many clocks have passed since the last accepted event on that pin. The third pin also feeds a non-maskable request. That path has its own enable and its own edge selection, so the two requests from the shared pin can be configured independently. Both may fire on the same transition.

Software uses a small register port. It writes one control word and reads back either the control word or any of the three counters.

Top module: `ext_irq_stamp`

## Requirements
- R1: While reset is asserted, and on the first clock after it, irqReq and nmiReq are low, the control word reads 0 and every counter reads 0.
- R2: For an input whose enable bit is 1 and polarity bit is 1, a low-to-high pin change that arrives between two rising clock edges raises irqReq for that input at the third rising clock edge after the change. The request stays high for exactly one clock.
- R3: For an enabled input whose polarity bit is 0, a high-to-low pin change raises that input's irqReq with the same latency as R2, for one clock.
- R4: An input whose enable bit is 0 raises no request on any transition, and its counter is not cleared by that transition and keeps counting.
- R5: For an enabled input, a transition in the direction opposite to its polarity bit raises no request.
- R6: Each counter increases by one on every clock on which it is not cleared, and wraps from 0xFFFF to 0x0000.
- R7: A counter reads 0 on the clock on which its input's irqReq is high, and 1 on the following clock.
- R8: Pin 2 also drives nmiReq. nmiReq is enabled by control bit 6 and uses polarity bit 7 (1 = rising, 0 = falling). These bits are independent of the masked settings for pin 2, and nmiReq follows the same timing as R2.
- R9: Register address 0 is the control word. Bit 2i enables input i and bit 2i+1 selects its polarity (1 = rising) for i = 0..2, and bits 6 and 7 are as in R8. Writes to address 0 store bits 7:0, and bits 15:8 read as 0. Addresses 1, 2 and 3 read the counters of inputs 0, 1 and 2. These addresses are read-only, and writes to them have no effect.
- R10: The three inputs are detected independently. Edges that arrive in the same clock on several enabled inputs each raise their own request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 3 | Raw external interrupt pins; bit 2 is shared with the non-maskable request |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 control, 1..3 counters) |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data, combinational from regAddr |
| irqReq | output | 3 | One-cycle maskable interrupt requests, one per pin |
| nmiReq | output | 1 | One-cycle non-maskable interrupt request from pin 2 |

## Verification
The assertions assume that pinIn is sampled only through the synchroniser, and that the control word is written through the register port. A request bit can then never be high on two consecutive clocks. They also assume the enable bit in force one clock before a request was set. To keep to this, the stimulus changes pins and register inputs only on falling clock edges. It writes the control word only while the pins are stable, and it leaves at least four clocks after a pin change before reconfiguring.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int NUM_IRQ = 3;
  localparam int NMI_PIN = 2;
  localparam int CTRL_W  = 2 * NUM_IRQ + 2;
  localparam int REG_AW  = $clog2(NUM_IRQ + 1);

  // Strobes from control to datapath, all valid for one clock
  typedef struct packed {
    logic [NUM_IRQ-1:0] clrCnt;
    logic [NUM_IRQ-1:0] irqFire;
    logic               nmiFire;
  } strobe_t;
endpackage

// File: rtl/ext_irq_dpath.sv
module ext_irq_dpath
  import ext_irq_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_IRQ-1:0]            pinIn,
  input  strobe_t                       strobes,
  output logic [NUM_IRQ-1:0]            riseHit,
  output logic [NUM_IRQ-1:0]            fallHit,
  output logic [NUM_IRQ-1:0][CNT_W-1:0] cntVec
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_IRQ-1:0] syncStage [SYNC_STAGES];
  logic [NUM_IRQ-1:0] prevLvl;
  logic [NUM_IRQ-1:0] pinLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncStage[s] <= '0;
      prevLvl <= '0;
    end else begin
      syncStage[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncStage[s] <= syncStage[s-1];
      prevLvl <= syncStage[LAST];
    end
  end

  assign pinLvl  = syncStage[LAST];
  assign riseHit = pinLvl & ~prevLvl;
  assign fallHit = ~pinLvl & prevLvl;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_cnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  cntVec[i] <= '0;
      else if (strobes.clrCnt[i]) cntVec[i] <= '0;
      else                        cntVec[i] <= cntVec[i] + 1'b1;
    end
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctrlWe,
  input  logic [CTRL_W-1:0]  ctrlWdata,
  input  logic [NUM_IRQ-1:0] riseHit,
  input  logic [NUM_IRQ-1:0] fallHit,
  output logic [CTRL_W-1:0]  ctrlWord,
  output strobe_t            strobes,
  output logic [NUM_IRQ-1:0] irqReq,
  output logic               nmiReq
);
  localparam int NMI_EN  = 2 * NUM_IRQ;
  localparam int NMI_POL = 2 * NUM_IRQ + 1;

  logic [NUM_IRQ-1:0] validEdge;
  logic               nmiEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       ctrlWord <= '0;
    else if (ctrlWe) ctrlWord <= ctrlWdata;
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_qual
    assign validEdge[i] = ctrlWord[2*i] &
                          (ctrlWord[2*i+1] ? riseHit[i] : fallHit[i]);
  end

  assign nmiEdge = ctrlWord[NMI_EN] &
                   (ctrlWord[NMI_POL] ? riseHit[NMI_PIN] : fallHit[NMI_PIN]);

  always_comb begin
    strobes.clrCnt  = validEdge;
    strobes.irqFire = validEdge;
    strobes.nmiFire = nmiEdge;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReq <= '0;
      nmiReq <= 1'b0;
    end else begin
      irqReq <= strobes.irqFire;
      nmiReq <= strobes.nmiFire;
    end
  end
endmodule

// File: rtl/ext_irq_stamp.sv
module ext_irq_stamp
  import ext_irq_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] pinIn,
  input  logic               regWe,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [CNT_W-1:0]   regWdata,
  output logic [CNT_W-1:0]   regRdata,
  output logic [NUM_IRQ-1:0] irqReq,
  output logic               nmiReq
);
  strobe_t                       strobes;
  logic [NUM_IRQ-1:0]            riseHit;
  logic [NUM_IRQ-1:0]            fallHit;
  logic [NUM_IRQ-1:0][CNT_W-1:0] cntVec;
  logic [CTRL_W-1:0]             ctrlWord;
  logic                          ctrlWe;
  logic                          unusedWdata;

  assign ctrlWe      = regWe && (regAddr == '0);
  assign unusedWdata = ^regWdata[CNT_W-1:CTRL_W];

  ext_irq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWe    (ctrlWe),
    .ctrlWdata (regWdata[CTRL_W-1:0]),
    .riseHit   (riseHit),
    .fallHit   (fallHit),
    .ctrlWord  (ctrlWord),
    .strobes   (strobes),
    .irqReq    (irqReq),
    .nmiReq    (nmiReq)
  );

  ext_irq_dpath #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .strobes (strobes),
    .riseHit (riseHit),
    .fallHit (fallHit),
    .cntVec  (cntVec)
  );

  always_comb begin
    regRdata = '0;
    if (regAddr == '0) regRdata = CNT_W'(ctrlWord);
    for (int i = 0; i < NUM_IRQ; i++)
      if (regAddr == REG_AW'(i + 1)) regRdata = cntVec[i];
  end
endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk
  import ext_irq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [CTRL_W-1:0]             ctrlWord,
  input logic [NUM_IRQ-1:0][CNT_W-1:0] cntVec,
  input logic [NUM_IRQ-1:0]            irqReq,
  input logic                          nmiReq
);
  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else        pastValid <= 1'b1;
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_chk
    // R2: request is a single-cycle pulse
    assert_one_cycle_R2: assert property (@(posedge clk) disable iff (!rstN)
      irqReq[i] |=> !irqReq[i]);
    // R4: no request unless enabled before it was raised
    assert_needs_enable_R4: assert property (@(posedge clk) disable iff (!rstN)
      irqReq[i] |-> $past(ctrlWord[2*i]));
    // R7: counter is zero alongside its request
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
      irqReq[i] |-> (cntVec[i] == '0));
    // R6: otherwise the counter steps by one, wrapping
    assert_step_R6: assert property (@(posedge clk) disable iff (!rstN)
      (pastValid && !irqReq[i]) |-> (cntVec[i] == CNT_W'($past(cntVec[i]) + 1'b1)));
  end

  assert_nmi_enable_R8: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |-> $past(ctrlWord[2*NUM_IRQ]));
  assert_nmi_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |=> !nmiReq);
endmodule

bind ext_irq_stamp ext_irq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .ctrlWord (ctrlWord),
  .cntVec   (cntVec),
  .irqReq   (irqReq),
  .nmiReq   (nmiReq)
);

// File: tb/tb_ext_irq_stamp.sv
module tb_ext_irq_stamp;
  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  pinDrv;
  logic        regWe;
  logic [1:0]  regAddr;
  logic [15:0] regWdata;
  logic [15:0] regRdata;
  logic [2:0]  irqReq;
  logic        nmiReq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ext_irq_stamp dut (
    .clk(clk), .rstN(rstN), .pinIn(pinDrv), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqReq(irqReq), .nmiReq(nmiReq)
  );

  // {ctrl[7:0], startPins[2:0], endPins[2:0], expIrq[2:0], expNmi}
  localparam int NVEC = 11;
  localparam logic [17:0] VEC [NVEC] = '{
    {8'h03, 3'b000, 3'b001, 3'b001, 1'b0},
    {8'h01, 3'b001, 3'b000, 3'b001, 1'b0},
    {8'h01, 3'b000, 3'b001, 3'b000, 1'b0},
    {8'h00, 3'b000, 3'b111, 3'b000, 1'b0},
    {8'h3F, 3'b000, 3'b111, 3'b111, 1'b0},
    {8'h0C, 3'b000, 3'b011, 3'b010, 1'b0},
    {8'hC0, 3'b000, 3'b100, 3'b000, 1'b1},
    {8'h40, 3'b100, 3'b000, 3'b000, 1'b1},
    {8'hF0, 3'b000, 3'b100, 3'b100, 1'b1},
    {8'h30, 3'b000, 3'b100, 3'b100, 1'b0},
    {8'hD0, 3'b000, 3'b100, 3'b000, 1'b1}
  };
  localparam string TAG [NVEC] = '{"R2", "R3", "R5", "R4", "R10", "R10",
                                   "R8", "R8", "R8", "R8", "R8"};

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    rstN = 1'b0; pinDrv = '0; regWe = 1'b0; regAddr = '0; regWdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(irqReq == 3'b000 && nmiReq == 1'b0, "R1 req", {irqReq, nmiReq}, 0);
    check(regRdata == 16'h0, "R1 ctrl", regRdata, 0);
    regAddr = 2'd3; #1;
    check(regRdata == 16'h0, "R1 cnt", regRdata, 0);
    regAddr = 2'd0;
    rstN = 1'b1;
    @(negedge clk);
    check(irqReq == 3'b000 && nmiReq == 1'b0, "R1 post", {irqReq, nmiReq}, 0);

    // R2/R7 exact latency on input 0
    wrReg(2'd0, 16'h0003);
    regAddr = 2'd1;
    pinDrv[0] = 1'b1;
    @(negedge clk);
    check(irqReq[0] == 1'b0, "R2 early1", irqReq, 0);
    @(negedge clk);
    check(irqReq[0] == 1'b0, "R2 early2", irqReq, 0);
    @(negedge clk);
    check(irqReq[0] == 1'b1, "R2 pulse", irqReq, 1);
    check(regRdata == 16'd0, "R7 clear", regRdata, 0);
    @(negedge clk);
    check(irqReq[0] == 1'b0, "R2 single", irqReq, 0);
    check(regRdata == 16'd1, "R7 next", regRdata, 1);

    // R6: count up and wrap
    repeat (65534) @(negedge clk);
    check(regRdata == 16'hFFFF, "R6 max", regRdata, 16'hFFFF);
    @(negedge clk);
    check(regRdata == 16'h0000, "R6 wrap", regRdata, 0);

    // R4: disabled input, counter not cleared
    wrReg(2'd0, 16'h0000);
    regAddr = 2'd1; #1;
    v = regRdata;
    pinDrv[0] = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check(irqReq == 3'b000, "R4 noreq", irqReq, 0);
    end
    check(regRdata == 16'(v + 4), "R4 keep", regRdata, 16'(v + 4));

    // R9: counter address is read-only
    @(negedge clk);
    regAddr = 2'd1; #1;
    v = regRdata;
    regWe = 1'b1; regWdata = 16'h0000;
    @(negedge clk);
    regWe = 1'b0;
    check(regRdata == 16'(v + 1), "R9 ro", regRdata, 16'(v + 1));
    // R9: control width
    wrReg(2'd0, 16'hFFA5);
    regAddr = 2'd0; #1;
    check(regRdata == 16'h00A5, "R9 ctrl", regRdata, 16'h00A5);

    // Vector table
    for (int k = 0; k < NVEC; k++) begin
      logic [2:0] seen;
      logic       nmiSeen;
      int         pulses;
      wrReg(2'd0, 16'h0000);
      pinDrv = VEC[k][9:7];
      repeat (4) @(negedge clk);
      wrReg(2'd0, {8'h00, VEC[k][17:10]});
      pinDrv = VEC[k][6:4];
      seen = '0; nmiSeen = 1'b0; pulses = 0;
      repeat (6) begin
        @(negedge clk);
        seen    = seen | irqReq;
        nmiSeen = nmiSeen | nmiReq;
        pulses  = pulses + $countones(irqReq) + int'(nmiReq);
      end
      check(seen == VEC[k][3:1] && nmiSeen == VEC[k][0] &&
            pulses == $countones(VEC[k][3:0]),
            TAG[k], {seen, nmiSeen}, VEC[k][3:0]);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule